// File: doc/BRIEF.md
# Tri-Protocol Host Register Port

This block gives a host processor single-register access to a bank of 256 eight-bit registers. One shared set of pins carries three bus protocols. With the serial-enable pin low, the port is a parallel bus with an 8-bit address. The controller-select pin then picks one of two strobe styles. In the first, a direction line is qualified by a data strobe. In the second, separate read and write strobes are used. With the serial-enable pin high, the same two control pins become the serial data input and the serial clock. A serial data output then returns read data.

Every host pin passes through a two-flop synchroniser into the system clock domain. Strobe edges are detected there, and each access is committed at most once. An access is armed by a falling edge on the active-low chip select. Exactly one read or write is allowed per chip-select assertion. An internal test-mode flag is set by reset and is cleared the first time chip select is seen high. The parallel data bus and the serial output are given as data/enable pairs, so the pad ring can build the tri-state drivers.

Top module: `hostreg_port`

## Requirements
- R1: `test_mode` is 1 after reset. It clears once `cs_n` has been seen high, and it never sets again before the next reset.
- R2: A register access is performed only after a high-to-low edge of `cs_n`. Only the first read or write of each chip-select assertion takes effect. Strobes before the first edge, and later strobes in the same assertion, change nothing.
- R3: With `ser_en`=0 and `ctl_sel`=0, `rw_wr_sdi`=1 selects a read and `rw_wr_sdi`=0 selects a write. Either is qualified by `ds_rd_sck` low. A read returns the addressed register on `d_out`.
- R4: With `ser_en`=0 and `ctl_sel`=1, `rw_wr_sdi` low is a write strobe and `ds_rd_sck` low is a read strobe.
- R5: With `ser_en`=1, the value of `ctl_sel` has no effect on serial transfers.
- R6: In serial mode, `rw_wr_sdi` is sampled on rising edges of `ds_rd_sck`. A frame is 17 bits, MSB first: one direction bit (1 = read), then 8 address bits, then 8 data bits. On a read, the register is shifted out MSB first on `sdo`, ready before rising edges 10 through 17.
- R7: While the serial output is enabled, `sdo` changes only after a falling edge of the serial clock.
- R8: In serial mode, the parallel `addr` bus is ignored.
- R9: `d_oe` is 1 only during a qualified parallel read with `cs_n` low. `sdo_oe` is 1 only while `cs_n` is low in serial mode, and is 0 whenever `cs_n` is high.
- R10: A write is committed exactly once per strobe assertion. The bank write enable is never high on two consecutive cycles.
- R11: All 256 registers store and return their values independently, whichever protocol wrote them and whichever protocol reads them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ser_en | input | 1 | 1 = serial mode, 0 = parallel mode |
| ctl_sel | input | 1 | Parallel strobe style: 0 = direction + data strobe, 1 = separate read/write strobes |
| rw_wr_sdi | input | 1 | Direction line / write strobe (active low) / serial data in |
| ds_rd_sck | input | 1 | Data strobe (active low) / read strobe (active low) / serial clock |
| addr | input | 8 | Parallel register address |
| d_in | input | 8 | Parallel write data from the pad |
| d_out | output | 8 | Parallel read data to the pad |
| d_oe | output | 1 | Parallel data bus output enable |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial output enable |
| test_mode | output | 1 | Internal test-mode flag |

## Verification
On every cycle, the assertions check the output-enable gating, the serial-clock alignment of changes on `sdo`, the single-cycle write enable, and the test-mode flag's one-way clearing. Only the bench's scenarios can show that data survives the trip through each protocol to the right register. A sweep writes all 256 registers, rotating over the three protocols, and reads every one back with a different protocol. The bench also varies `ctl_sel` and drives a wrong parallel address during serial frames. Strobes issued without a fresh chip-select edge are shown to be ignored by later read-back.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  typedef enum logic [1:0] {
    MODE_DSTROBE = 2'd0,
    MODE_RWSTROBE = 2'd1,
    MODE_SERIAL = 2'd2
  } host_mode_e;

  function automatic host_mode_e pick_mode(input logic ser, input logic ctl);
    if (ser) return MODE_SERIAL;
    else if (ctl) return MODE_RWSTROBE;
    else return MODE_DSTROBE;
  endfunction
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hrp_regbank.sv
module hrp_regbank #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hrp_par.sv
module hrp_par #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          rwstyle,
  input  logic          armed,
  input  logic          line_a,
  input  logic          line_b,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  output logic          wr_go,
  output logic          rd_go,
  output logic          rd_on,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  logic wr_lvl, rd_lvl, wr_prev, rd_prev, rd_hold;

  always_comb begin
    if (rwstyle) begin
      wr_lvl = !line_a;
      rd_lvl = !line_b;
    end else begin
      wr_lvl = !line_b && !line_a;
      rd_lvl = !line_b && line_a;
    end
  end

  assign wr_go = sel && armed && wr_lvl && !wr_prev;
  assign rd_go = sel && armed && rd_lvl && !rd_prev && !wr_lvl;
  assign rd_on = rd_hold && sel && rd_lvl;
  assign addr_o = addr_i;
  assign wdata_o = din_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
      rd_hold <= 1'b0;
    end else begin
      wr_prev <= sel && wr_lvl;
      rd_prev <= sel && rd_lvl;
      if (rd_go) rd_hold <= 1'b1;
      else if (!(sel && rd_lvl)) rd_hold <= 1'b0;
    end
  end
endmodule

// File: rtl/hrp_spi.sv
module hrp_spi #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          armed,
  input  logic          sck,
  input  logic          sdi,
  input  logic [DW-1:0] rdata,
  output logic          wr_go,
  output logic          rd_go,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          sdo,
  output logic          sck_fall
);
  localparam int FRAME = 1 + AW + DW;
  localparam int CW = $clog2(FRAME + 1);
  localparam int OCW = $clog2(DW + 1);

  logic             sck_prev, hdr_evt, frm_evt, is_rd, rise;
  logic [CW-1:0]    cnt;
  logic [FRAME-1:0] sh;
  logic [DW-1:0]    osh;
  logic [OCW-1:0]   ocnt;

  assign rise = sel && sck && !sck_prev;
  assign sck_fall = sel && !sck && sck_prev;

  assign rd_go = hdr_evt && sel && armed && sh[AW];
  assign wr_go = frm_evt && sel && armed && !sh[FRAME-1];
  assign addr_o = frm_evt ? sh[FRAME-2:DW] : sh[AW-1:0];
  assign wdata_o = sh[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev <= 1'b0;
      hdr_evt <= 1'b0;
      frm_evt <= 1'b0;
      is_rd <= 1'b0;
      cnt <= '0;
      sh <= '0;
      osh <= '0;
      ocnt <= '0;
      sdo <= 1'b0;
    end else begin
      sck_prev <= sck;
      hdr_evt <= rise && (cnt == CW'(AW));
      frm_evt <= rise && (cnt == CW'(FRAME - 1));
      if (!sel) begin
        cnt <= '0;
        sh <= '0;
        is_rd <= 1'b0;
        osh <= '0;
        ocnt <= '0;
        sdo <= 1'b0;
      end else begin
        if (rise && (cnt < CW'(FRAME))) begin
          sh <= {sh[FRAME-2:0], sdi};
          cnt <= cnt + 1'b1;
        end
        if (rd_go) is_rd <= 1'b1;
        if (sck_fall && is_rd && (ocnt < OCW'(DW))) begin
          if (ocnt == '0) begin
            sdo <= rdata[DW-1];
            osh <= {rdata[DW-2:0], 1'b0};
          end else begin
            sdo <= osh[DW-1];
            osh <= {osh[DW-2:0], 1'b0};
          end
          ocnt <= ocnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
  import hrp_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          ser_en,
  input  logic          ctl_sel,
  input  logic          rw_wr_sdi,
  input  logic          ds_rd_sck,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_out,
  output logic          d_oe,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          test_mode
);
  localparam int NSYNC = 5 + AW + DW;

  logic [NSYNC-1:0] raw_v, syn_v;
  logic             cs_s, ser_s, ctl_s, la_s, lb_s;
  logic [AW-1:0]    addr_s;
  logic [DW-1:0]    din_s;
  host_mode_e       mode;

  assign raw_v = {cs_n, ser_en, ctl_sel, rw_wr_sdi, ds_rd_sck, addr, d_in};

  hrp_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_v), .q(syn_v)
  );

  assign {cs_s, ser_s, ctl_s, la_s, lb_s, addr_s, din_s} = syn_v;
  assign mode = pick_mode(ser_s, ctl_s);

  logic cs_prev, armed, cs_fell, par_sel, spi_sel;
  assign cs_fell = cs_prev && !cs_s;
  assign par_sel = !cs_s && (mode != MODE_SERIAL);
  assign spi_sel = !cs_s && (mode == MODE_SERIAL);

  logic          par_wr_go, par_rd_go, par_rd_on;
  logic [AW-1:0] par_addr;
  logic [DW-1:0] par_wdata;

  hrp_par #(.AW(AW), .DW(DW)) u_par (
    .clk(clk), .rst(rst), .sel(par_sel), .rwstyle(mode == MODE_RWSTROBE),
    .armed(armed), .line_a(la_s), .line_b(lb_s), .addr_i(addr_s), .din_i(din_s),
    .wr_go(par_wr_go), .rd_go(par_rd_go), .rd_on(par_rd_on),
    .addr_o(par_addr), .wdata_o(par_wdata)
  );

  logic          spi_wr_go, spi_rd_go, spi_sck_fall, spi_sdo;
  logic [AW-1:0] spi_addr;
  logic [DW-1:0] spi_wdata;
  logic [DW-1:0] rdata;

  hrp_spi #(.AW(AW), .DW(DW)) u_spi (
    .clk(clk), .rst(rst), .sel(spi_sel), .armed(armed), .sck(lb_s), .sdi(la_s),
    .rdata(rdata), .wr_go(spi_wr_go), .rd_go(spi_rd_go), .addr_o(spi_addr),
    .wdata_o(spi_wdata), .sdo(spi_sdo), .sck_fall(spi_sck_fall)
  );

  logic          bank_we;
  logic [AW-1:0] bank_waddr, rd_addr;
  logic [DW-1:0] bank_wdata;

  assign bank_we = par_wr_go || spi_wr_go;
  assign bank_waddr = par_wr_go ? par_addr : spi_addr;
  assign bank_wdata = par_wr_go ? par_wdata : spi_wdata;

  hrp_regbank #(.AW(AW), .DW(DW)) u_bank (
    .clk(clk), .we(bank_we), .waddr(bank_waddr), .wdata(bank_wdata),
    .raddr(rd_addr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev <= 1'b0;
      armed <= 1'b0;
      rd_addr <= '0;
      test_mode <= 1'b1;
      d_out <= '0;
      d_oe <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      cs_prev <= cs_s;
      if (cs_s) armed <= 1'b0;
      else if (cs_fell) armed <= 1'b1;
      else if (par_wr_go || par_rd_go || spi_wr_go || spi_rd_go) armed <= 1'b0;
      if (par_rd_go) rd_addr <= par_addr;
      else if (spi_rd_go) rd_addr <= spi_addr;
      if (cs_s) test_mode <= 1'b0;
      d_out <= rdata;
      d_oe <= par_rd_on;
      sdo_oe <= spi_sel;
    end
  end

  assign sdo = spi_sdo;
endmodule

// File: rtl/hostreg_port_chk.sv
module hostreg_port_chk (
  input logic clk,
  input logic rst,
  input logic cs_s,
  input logic ser_s,
  input logic d_oe,
  input logic sdo,
  input logic sdo_oe,
  input logic sck_fall,
  input logic bank_we,
  input logic test_mode
);
  // R1
  test_stays_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !test_mode |=> !test_mode);
  // R1
  test_clears_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !test_mode);
  // R2
  no_write_deselected_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |-> !bank_we);
  // R9
  par_oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    d_oe |-> $past(!cs_s && !ser_s));
  // R9
  sdo_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !sdo_oe);
  // R10
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    bank_we |=> !bank_we);
  // R7
  sdo_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe && $past(sdo_oe) && (sdo != $past(sdo))) |-> $past(sck_fall));
endmodule

bind hostreg_port hostreg_port_chk u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .ser_s(ser_s), .d_oe(d_oe), .sdo(sdo),
  .sdo_oe(sdo_oe), .sck_fall(spi_sck_fall), .bank_we(bank_we), .test_mode(test_mode)
);

// File: tb/sim_hostreg_port.sv
`timescale 1ns/1ps
module sim_hostreg_port;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b0, ser_en = 1'b0, ctl_sel = 1'b0, pa = 1'b1, pb = 1'b1;
  logic [7:0] addr = '0, d_in = '0;
  logic [7:0] d_out;
  logic d_oe, sdo, sdo_oe, test_mode;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hostreg_port u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ser_en(ser_en), .ctl_sel(ctl_sel),
    .rw_wr_sdi(pa), .ds_rd_sck(pb), .addr(addr), .d_in(d_in),
    .d_out(d_out), .d_oe(d_oe), .sdo(sdo), .sdo_oe(sdo_oe), .test_mode(test_mode)
  );

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int a);
    return 8'(((a * 37) + 11) ^ (a >> 2));
  endfunction

  // m: 0 = direction+data strobe (R3), 1 = separate strobes (R4)
  task automatic par_acc(int m, bit wr, logic [7:0] a, logic [7:0] d,
                         output logic [7:0] q, output logic oe);
    ser_en = 1'b0; ctl_sel = (m == 1); pa = 1'b1; pb = 1'b1; cs_n = 1'b1;
    wt(6);
    addr = a; d_in = d;
    if (m == 0) pa = !wr;
    wt(4);
    cs_n = 1'b0; wt(6);
    if (m == 0 || !wr) pb = 1'b0; else pa = 1'b0;
    wt(12);
    q = d_out; oe = d_oe;
    pb = 1'b1; if (m == 1) pa = 1'b1;
    wt(3);
    pa = 1'b1; wt(6);
    cs_n = 1'b1; wt(6);
  endtask

  task automatic spi_acc(bit rd, logic [7:0] a, logic [7:0] d, logic cs_sel,
                         output logic [7:0] q, output logic oe_mid);
    logic [16:0] frame;
    ser_en = 1'b1; ctl_sel = cs_sel; pa = 1'b0; pb = 1'b0; cs_n = 1'b1;
    wt(6);
    addr = ~a; // R8: wrong parallel address during serial frame
    cs_n = 1'b0; wt(6);
    frame = {rd, a, rd ? 8'h00 : d};
    q = '0; oe_mid = 1'b0;
    for (int i = 0; i < 17; i++) begin
      pa = frame[16-i];
      wt(HALF);
      if (i >= 9) q = {q[6:0], sdo};
      if (i == 12) oe_mid = sdo_oe;
      pb = 1'b1; wt(HALF);
      pb = 1'b0;
    end
    wt(HALF);
    cs_n = 1'b1; wt(6);
  endtask

  task automatic do_write(int m, logic [7:0] a, logic [7:0] d);
    logic [7:0] q; logic oe;
    if (m == 2) begin
      spi_acc(1'b0, a, d, a[0], q, oe);
      chk(oe == 1'b1, "R9 sdo_oe during frame", oe, 1);
    end else begin
      par_acc(m, 1'b1, a, d, q, oe);
      chk(oe == 1'b0, "R9 d_oe idle on write", oe, 0);
    end
  endtask

  task automatic do_read(int m, logic [7:0] a, logic [7:0] exp);
    logic [7:0] q; logic oe;
    if (m == 2) begin
      spi_acc(1'b1, a, 8'h00, ~a[0], q, oe);
      chk(q == exp, "R6 R5 R8 R11 serial read", q, exp);
      chk(oe == 1'b1, "R9 sdo_oe during read", oe, 1);
    end else begin
      par_acc(m, 1'b0, a, 8'h00, q, oe);
      chk(q == exp, (m == 0) ? "R3 R11 dstrobe read" : "R4 R11 rwstrobe read", q, exp);
      chk(oe == 1'b1, "R9 d_oe on read", oe, 1);
    end
    chk(!d_oe && !sdo_oe, "R9 enables off after cs high", {d_oe, sdo_oe}, 0);
  endtask

  initial begin
    wt(5);
    rst = 1'b0;
    wt(4);
    chk(test_mode == 1'b1, "R1 test_mode after reset", test_mode, 1);
    chk(d_oe == 1'b0, "R9 d_oe after reset", d_oe, 0);
    chk(sdo_oe == 1'b0, "R9 sdo_oe after reset", sdo_oe, 0);
    // R2: read strobe with cs held low since reset (no falling edge)
    pa = 1'b1; pb = 1'b0; wt(12);
    chk(d_oe == 1'b0, "R2 read without cs edge", d_oe, 0);
    chk(test_mode == 1'b1, "R1 test_mode while cs low", test_mode, 1);
    pb = 1'b1; wt(4);
    cs_n = 1'b1; wt(6);
    chk(test_mode == 1'b0, "R1 test_mode cleared", test_mode, 0);
    cs_n = 1'b0; wt(6); cs_n = 1'b1; wt(6);
    chk(test_mode == 1'b0, "R1 test_mode stays clear", test_mode, 0);

    for (int a = 0; a < 256; a++) do_write(a % 3, 8'(a), pat(a));
    for (int a = 0; a < 256; a++) do_read((a + 1) % 3, 8'(a), pat(a));

    // R2 R10: second strobe in the same cs assertion is ignored
    ser_en = 1'b0; ctl_sel = 1'b0; pa = 1'b0; pb = 1'b1; cs_n = 1'b1; wt(6);
    addr = 8'h10; d_in = 8'h5A; cs_n = 1'b0; wt(6);
    pb = 1'b0; wt(10); pb = 1'b1; wt(6);
    d_in = 8'hC3; pb = 1'b0; wt(10); pb = 1'b1; wt(6);
    addr = 8'h11; pb = 1'b0; wt(10); pb = 1'b1; wt(6);
    pa = 1'b1; cs_n = 1'b1; wt(6);
    do_read(1, 8'h10, 8'h5A);
    do_read(0, 8'h11, pat(8'h11));

    // R4: write strobe held long commits once with the captured data
    ser_en = 1'b0; ctl_sel = 1'b1; pa = 1'b1; pb = 1'b1; cs_n = 1'b1; wt(6);
    addr = 8'hF0; d_in = 8'h77; cs_n = 1'b0; wt(6);
    pa = 1'b0; wt(6); d_in = 8'h88; wt(20); pa = 1'b1; wt(6); cs_n = 1'b1; wt(6);
    do_read(2, 8'hF0, 8'h77);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule